// File: doc/BRIEF.md
# Selective Bus-Monitor Capture Filter with Stack Manager

This block is the front end of a serial-bus word monitor. For every command word it observes, it checks a selection table that the host loads. The table has one 32-bit mask row per remote-terminal address and direction, with one bit per subaddress. If the bit for the command is clear, the message is dropped and leaves no trace. If the bit is set, the block lays down a four-word descriptor in a command stack and streams the message's data words into a separate data stack. The RAM sits outside the block, and the block drives the write address, the enable and the word for each stack.

Both stack pointers wrap modulo a power-of-two size. When a pointer reaches the midpoint of its stack, the block raises a one-cycle pulse. It raises another pulse when the pointer returns to zero. The host can poll an event queue for these pulses. Each queue entry is a 4-bit mask of the rollover pulses seen in one cycle. When the queue is full, new entries are dropped and a sticky overflow flag is set.

Top module: `bmon_filter_stack`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both stack write enables, all four rollover pulses and `evq_overflow` are low, both write addresses are zero and `evq_empty` is high.
- R2: The command word fields are: remote address in bits 15..11, direction in bit 10 and subaddress in bits 9..5. The message is captured when bit `subaddress` of table row `{address, direction}` is set. A command sampled at edge N while idle produces command-stack writes at entry offsets +1, +2 and +3, visible after edges N+1, N+2 and N+3. The word at +2 is the command word.
- R3: In a captured message's descriptor, offset +0 holds `blk_status` from `msg_done`, offset +1 holds `time_tag` sampled with the command, and offset +3 holds the data-stack address of the message's first data word.
- R4: A message whose selection bit is clear makes no write to either stack. Its `data_valid` and `msg_done` strobes are ignored, and neither pointer moves.
- R5: Each `data_valid` during a captured message writes `data_word` at the current data pointer one edge later. The pointer then advances by one, modulo `DSTK_WORDS`.
- R6: `msg_done` ends a captured message. It writes offset +0 and advances the command pointer by four words, modulo `CSTK_WORDS`.
- R7: `cmd_half_irq` or `dat_half_irq` pulses for exactly one cycle, together with the write that moves its pointer onto half the stack size.
- R8: `cmd_full_irq` or `dat_full_irq` pulses for exactly one cycle, together with the write that wraps its pointer back to zero.
- R9: Each cycle with any rollover pulse queues one entry, with bit 3 = data full, bit 2 = data half, bit 1 = command full and bit 0 = command half. Entries are read out in arrival order at `evq_head`, and `evq_pop` advances the queue by one entry.
- R10: When the queue already holds `EVQ_DEPTH` entries, a new entry is discarded and `evq_overflow` is set. The flag stays set until reset.
- R11: A table write to row `tbl_row` replaces that row's mask. The new mask applies to commands sampled after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Selection table write strobe |
| tbl_row | input | 6 | Table row, {address, direction} |
| tbl_mask | input | 32 | Subaddress capture mask for the row |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Decoded command word |
| time_tag | input | 16 | Time stamp sampled with the command |
| data_valid | input | 1 | Data word strobe |
| data_word | input | 16 | Data word |
| msg_done | input | 1 | End of message strobe |
| blk_status | input | 16 | Message status word |
| cstk_we | output | 1 | Command stack write enable |
| cstk_addr | output | $clog2(CSTK_WORDS) | Command stack word address |
| cstk_wdata | output | 16 | Command stack write word |
| dstk_we | output | 1 | Data stack write enable |
| dstk_addr | output | $clog2(DSTK_WORDS) | Data stack word address |
| dstk_wdata | output | 16 | Data stack write word |
| cmd_half_irq | output | 1 | Command stack midpoint pulse |
| cmd_full_irq | output | 1 | Command stack wrap pulse |
| dat_half_irq | output | 1 | Data stack midpoint pulse |
| dat_full_irq | output | 1 | Data stack wrap pulse |
| evq_pop | input | 1 | Remove head queue entry |
| evq_empty | output | 1 | Event queue empty |
| evq_head | output | 4 | Oldest queue entry |
| evq_overflow | output | 1 | Sticky queue overflow |

## Verification
The properties assume well-spaced message framing. Data strobes start no earlier than the second edge after the command. `msg_done` comes at least four edges after the command. `msg_done` never coincides with a data strobe, and a new command arrives only once the previous message has closed. The stimulus tasks follow this framing: one command cycle, two quiet cycles, the data words, two quiet cycles and then the end strobe. The bench also never writes a table row in the same cycle as a command that reads it. The queue is drained only between messages, so the pop strobe never meets a push.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  localparam int WORD_W   = 16;
  localparam int RT_W     = 5;
  localparam int SA_N     = 32;
  localparam int ROWS     = 64;
  localparam int EVT_W    = 4;
  localparam int DESC_LEN = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOOK,
    PH_CMD,
    PH_DP,
    PH_BODY
  } bmon_phase_e;
endpackage

// File: rtl/bmon_sel_table.sv
module bmon_sel_table #(
  parameter int ROWS = 64,
  parameter int COLS = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(ROWS)-1:0]  waddr,
  input  logic [COLS-1:0]          wdata,
  input  logic                     re,
  input  logic [$clog2(ROWS)-1:0]  raddr,
  output logic [COLS-1:0]          rdata
);
  logic [COLS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bmon_stack_ptr.sv
module bmon_stack_ptr #(
  parameter int SIZE = 256,
  parameter int STEP = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  output logic [$clog2(SIZE)-1:0] ptr,
  output logic                    half_pls,
  output logic                    full_pls
);
  localparam int AW = $clog2(SIZE);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] HALF_V = AW'(SIZE / 2);

  logic [AW-1:0] nxt;
  assign nxt = ptr + STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      half_pls <= 1'b0;
      full_pls <= 1'b0;
    end else begin
      half_pls <= adv && (nxt == HALF_V);
      full_pls <= adv && (nxt == '0);
      if (adv) ptr <= nxt;
    end
  end
endmodule

// File: rtl/bmon_evt_queue.sv
module bmon_evt_queue #(
  parameter int DEPTH = 32,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_V = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [AW:0]   cnt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == FULL_V);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_p];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p     <= '0;
      rd_p     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_p <= wr_p + 1'b1;
      if (do_pop)  rd_p <= rd_p + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/bmon_filter_stack.sv
module bmon_filter_stack
  import bmon_pkg::*;
#(
  parameter int CSTK_WORDS = 256,
  parameter int DSTK_WORDS = 1024,
  parameter int EVQ_DEPTH  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tbl_we,
  input  logic [5:0]                    tbl_row,
  input  logic [31:0]                   tbl_mask,
  input  logic                          cmd_valid,
  input  logic [15:0]                   cmd_word,
  input  logic [15:0]                   time_tag,
  input  logic                          data_valid,
  input  logic [15:0]                   data_word,
  input  logic                          msg_done,
  input  logic [15:0]                   blk_status,
  output logic                          cstk_we,
  output logic [$clog2(CSTK_WORDS)-1:0] cstk_addr,
  output logic [15:0]                   cstk_wdata,
  output logic                          dstk_we,
  output logic [$clog2(DSTK_WORDS)-1:0] dstk_addr,
  output logic [15:0]                   dstk_wdata,
  output logic                          cmd_half_irq,
  output logic                          cmd_full_irq,
  output logic                          dat_half_irq,
  output logic                          dat_full_irq,
  input  logic                          evq_pop,
  output logic                          evq_empty,
  output logic [3:0]                    evq_head,
  output logic                          evq_overflow
);
  localparam int CAW = $clog2(CSTK_WORDS);
  localparam int DAW = $clog2(DSTK_WORDS);
  localparam int RAW = $clog2(ROWS);

  bmon_phase_e   phase;
  logic [15:0]   cmd_q, tt_q;
  logic [DAW-1:0] dsnap;
  logic [SA_N-1:0] row_bits;
  logic [CAW-1:0] cptr;
  logic [DAW-1:0] dptr;
  logic [CAW-3:0] cbase;
  logic          lookup_re, capturing, cadv, dadv;
  logic [EVT_W-1:0] evt;

  assign lookup_re = cmd_valid && (phase == PH_IDLE);
  assign capturing = (phase == PH_CMD) || (phase == PH_DP) || (phase == PH_BODY);
  assign dadv      = data_valid && capturing;
  assign cadv      = msg_done && (phase == PH_BODY);
  assign cbase     = cptr[CAW-1:2];

  bmon_sel_table #(.ROWS(ROWS), .COLS(SA_N)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_row),
    .wdata (tbl_mask),
    .re    (lookup_re),
    .raddr (cmd_word[15:15-RAW+1]),
    .rdata (row_bits)
  );

  bmon_stack_ptr #(.SIZE(CSTK_WORDS), .STEP(DESC_LEN)) u_cptr (
    .clk      (clk),
    .rst      (rst),
    .adv      (cadv),
    .ptr      (cptr),
    .half_pls (cmd_half_irq),
    .full_pls (cmd_full_irq)
  );

  bmon_stack_ptr #(.SIZE(DSTK_WORDS), .STEP(1)) u_dptr (
    .clk      (clk),
    .rst      (rst),
    .adv      (dadv),
    .ptr      (dptr),
    .half_pls (dat_half_irq),
    .full_pls (dat_full_irq)
  );

  // Descriptor sequencer: +1 tag, +2 command, +3 data pointer, +0 status at end.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cmd_q      <= '0;
      tt_q       <= '0;
      dsnap      <= '0;
      cstk_we    <= 1'b0;
      cstk_addr  <= '0;
      cstk_wdata <= '0;
    end else begin
      cstk_we <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (cmd_valid) begin
            cmd_q <= cmd_word;
            tt_q  <= time_tag;
            phase <= PH_LOOK;
          end
        end
        PH_LOOK: begin
          if (row_bits[cmd_q[9:5]]) begin
            cstk_we    <= 1'b1;
            cstk_addr  <= {cbase, 2'd1};
            cstk_wdata <= tt_q;
            dsnap      <= dptr;
            phase      <= PH_CMD;
          end else begin
            phase <= PH_IDLE;
          end
        end
        PH_CMD: begin
          cstk_we    <= 1'b1;
          cstk_addr  <= {cbase, 2'd2};
          cstk_wdata <= cmd_q;
          phase      <= PH_DP;
        end
        PH_DP: begin
          cstk_we    <= 1'b1;
          cstk_addr  <= {cbase, 2'd3};
          cstk_wdata <= 16'(dsnap);
          phase      <= PH_BODY;
        end
        PH_BODY: begin
          if (msg_done) begin
            cstk_we    <= 1'b1;
            cstk_addr  <= {cbase, 2'd0};
            cstk_wdata <= blk_status;
            phase      <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Data stream writer
  always_ff @(posedge clk) begin
    if (rst) begin
      dstk_we    <= 1'b0;
      dstk_addr  <= '0;
      dstk_wdata <= '0;
    end else begin
      dstk_we <= dadv;
      if (dadv) begin
        dstk_addr  <= dptr;
        dstk_wdata <= data_word;
      end
    end
  end

  assign evt = {dat_full_irq, dat_half_irq, cmd_full_irq, cmd_half_irq};

  bmon_evt_queue #(.DEPTH(EVQ_DEPTH), .W(EVT_W)) u_evq (
    .clk      (clk),
    .rst      (rst),
    .push     (|evt),
    .din      (evt),
    .pop      (evq_pop),
    .empty    (evq_empty),
    .head     (evq_head),
    .overflow (evq_overflow)
  );
endmodule

// File: rtl/bmon_filter_stack_chk.sv
module bmon_filter_stack_chk #(
  parameter int CSTK_WORDS = 256,
  parameter int DSTK_WORDS = 1024
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cstk_we,
  input logic [$clog2(CSTK_WORDS)-1:0] cstk_addr,
  input logic                          dstk_we,
  input logic [$clog2(DSTK_WORDS)-1:0] dstk_addr,
  input logic                          cmd_half_irq,
  input logic                          cmd_full_irq,
  input logic                          dat_half_irq,
  input logic                          dat_full_irq,
  input logic                          evq_empty,
  input logic                          evq_overflow
);
  localparam int CAW = $clog2(CSTK_WORDS);
  localparam int DAW = $clog2(DSTK_WORDS);
  localparam logic [CAW-1:0] C_HALF_LAST = CAW'(CSTK_WORDS / 2 - 4);
  localparam logic [CAW-1:0] C_LAST      = CAW'(CSTK_WORDS - 4);
  localparam logic [DAW-1:0] D_HALF_LAST = DAW'(DSTK_WORDS / 2 - 1);
  localparam logic [DAW-1:0] D_LAST      = DAW'(DSTK_WORDS - 1);

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cstk_we && !dstk_we && evq_empty && !evq_overflow)); // R1

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
    (dstk_we && $past(dstk_we)) |-> (dstk_addr == $past(dstk_addr) + 1'b1)); // R5

  AST_CMD_HALF_AT: assert property (@(posedge clk) disable iff (rst)
    cmd_half_irq |-> (cstk_we && cstk_addr == C_HALF_LAST)); // R7

  AST_DAT_HALF_AT: assert property (@(posedge clk) disable iff (rst)
    dat_half_irq |-> (dstk_we && dstk_addr == D_HALF_LAST)); // R7

  AST_CMD_HALF_ONCE: assert property (@(posedge clk) disable iff (rst)
    cmd_half_irq |=> !cmd_half_irq); // R7

  AST_CMD_WRAP_AT: assert property (@(posedge clk) disable iff (rst)
    cmd_full_irq |-> (cstk_we && cstk_addr == C_LAST)); // R8

  AST_DAT_WRAP_AT: assert property (@(posedge clk) disable iff (rst)
    dat_full_irq |-> (dstk_we && dstk_addr == D_LAST)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(evq_overflow) |-> evq_overflow); // R10
endmodule

bind bmon_filter_stack bmon_filter_stack_chk #(
  .CSTK_WORDS(CSTK_WORDS),
  .DSTK_WORDS(DSTK_WORDS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cstk_we      (cstk_we),
  .cstk_addr    (cstk_addr),
  .dstk_we      (dstk_we),
  .dstk_addr    (dstk_addr),
  .cmd_half_irq (cmd_half_irq),
  .cmd_full_irq (cmd_full_irq),
  .dat_half_irq (dat_half_irq),
  .dat_full_irq (dat_full_irq),
  .evq_empty    (evq_empty),
  .evq_overflow (evq_overflow)
);

// File: tb/test_bmon_filter_stack.sv
module test_bmon_filter_stack;
  localparam int TC = 32;
  localparam int TD = 16;
  localparam int TQ = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 0; logic [5:0] tbl_row = 0; logic [31:0] tbl_mask = 0;
  logic cmd_valid = 0; logic [15:0] cmd_word = 0; logic [15:0] time_tag = 0;
  logic data_valid = 0; logic [15:0] data_word = 0;
  logic msg_done = 0; logic [15:0] blk_status = 0;
  logic evq_pop = 0;
  logic cstk_we, dstk_we;
  logic [4:0] cstk_addr; logic [3:0] dstk_addr;
  logic [15:0] cstk_wdata, dstk_wdata;
  logic cmd_half_irq, cmd_full_irq, dat_half_irq, dat_full_irq;
  logic evq_empty, evq_overflow; logic [3:0] evq_head;

  always #5 clk = ~clk;

  bmon_filter_stack #(.CSTK_WORDS(TC), .DSTK_WORDS(TD), .EVQ_DEPTH(TQ)) i_bmon_filter_stack (.*);

  int n_chk = 0, n_bad = 0;
  logic [15:0] cmem [TC];
  logic [15:0] dmem [TD];
  int ccnt = 0, dcnt = 0, n_ch = 0, n_cf = 0, n_dh = 0, n_df = 0;
  logic [31:0] mtab [64];
  int mc = 0, md = 0, e_ch = 0, e_cf = 0, e_dh = 0, e_df = 0;
  int expq[$];
  bit mov = 0;
  logic [15:0] ttag = 16'h1000;

  always @(negedge clk) begin
    if (!rst) begin
      if (cstk_we) begin cmem[cstk_addr] = cstk_wdata; ccnt++; end
      if (dstk_we) begin dmem[dstk_addr] = dstk_wdata; dcnt++; end
      if (cmd_half_irq) n_ch++;
      if (cmd_full_irq) n_cf++;
      if (dat_half_irq) n_dh++;
      if (dat_full_irq) n_df++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qpush(input int e);
    if (expq.size() < TQ) expq.push_back(e); else mov = 1;
  endtask

  task automatic tbl_write(input logic [5:0] row, input logic [31:0] m);
    @(negedge clk); tbl_we = 1; tbl_row = row; tbl_mask = m; mtab[row] = m;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic send_msg(input logic [4:0] rt, input logic tr, input logic [4:0] sa,
                          input int nd, input logic [15:0] st, input string tag);
    logic [15:0] cw, tt;
    bit sel;
    int c0, d0, base, ds;
    cw = {rt, tr, sa, 5'(nd)};
    tt = ttag; ttag = ttag + 16'h11;
    sel = mtab[{rt, tr}][sa];
    c0 = ccnt; d0 = dcnt; base = mc; ds = md;
    @(negedge clk); cmd_valid = 1; cmd_word = cw; time_tag = tt;
    @(negedge clk); cmd_valid = 0;
    @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      @(negedge clk); data_valid = 1; data_word = 16'hA000 ^ 16'(i * 7 + int'(st));
      if (sel) begin
        md = (md + 1) % TD;
        if (md == TD / 2) begin e_dh++; qpush(4); end
        if (md == 0)      begin e_df++; qpush(8); end
      end
    end
    @(negedge clk); data_valid = 0;
    @(negedge clk);
    @(negedge clk); msg_done = 1; blk_status = st;
    @(negedge clk); msg_done = 0;
    if (sel) begin
      mc = (mc + 4) % TC;
      if (mc == TC / 2) begin e_ch++; qpush(1); end
      if (mc == 0)      begin e_cf++; qpush(2); end
    end
    @(negedge clk);
    @(negedge clk);
    chk(ccnt - c0 == (sel ? 4 : 0), {tag, " R2/R4 cmd writes"}, ccnt - c0, sel ? 4 : 0);
    chk(dcnt - d0 == (sel ? nd : 0), {tag, " R5/R4 data writes"}, dcnt - d0, sel ? nd : 0);
    if (sel) begin
      chk(cmem[base + 2] == cw, {tag, " R2 command word"}, cmem[base + 2], cw);
      chk(cmem[base + 1] == tt, {tag, " R3 time tag"}, cmem[base + 1], tt);
      chk(cmem[base + 3] == 16'(ds), {tag, " R3 data pointer"}, cmem[base + 3], ds);
      chk(cmem[base] == st, {tag, " R3/R6 status"}, cmem[base], st);
      if (nd <= TD)
        for (int i = 0; i < nd; i++)
          chk(dmem[(ds + i) % TD] == (16'hA000 ^ 16'(i * 7 + int'(st))), {tag, " R5 data"},
              dmem[(ds + i) % TD], 16'hA000 ^ 16'(i * 7 + int'(st)));
    end
    chk(n_ch == e_ch, {tag, " R7 cmd half pulses"}, n_ch, e_ch);
    chk(n_dh == e_dh, {tag, " R7 data half pulses"}, n_dh, e_dh);
    chk(n_cf == e_cf, {tag, " R8 cmd wrap pulses"}, n_cf, e_cf);
    chk(n_df == e_df, {tag, " R8 data wrap pulses"}, n_df, e_df);
  endtask

  task automatic drain_queue(input string tag);
    while (expq.size() > 0) begin
      @(negedge clk);
      chk(!evq_empty, {tag, " R9 queue has entry"}, evq_empty, 0);
      chk(evq_head == 4'(expq[0]), {tag, " R9 entry order"}, evq_head, expq[0]);
      void'(expq.pop_front());
      evq_pop = 1;
      @(negedge clk); evq_pop = 0;
    end
    @(negedge clk);
    chk(evq_empty, {tag, " R9 queue drained"}, evq_empty, 1);
    chk(evq_overflow == mov, {tag, " R10 overflow flag"}, evq_overflow, mov);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(!cstk_we && !dstk_we, "R1 enables low in reset", {cstk_we, dstk_we}, 0);
    rst = 0;
    @(negedge clk);
    chk(!cstk_we && !dstk_we, "R1 enables low", {cstk_we, dstk_we}, 0);
    chk(cstk_addr == 0 && dstk_addr == 0, "R1 addresses zero", {cstk_addr, dstk_addr}, 0);
    chk(!(cmd_half_irq | cmd_full_irq | dat_half_irq | dat_full_irq), "R1 pulses low",
        {cmd_half_irq, cmd_full_irq, dat_half_irq, dat_full_irq}, 0);
    chk(evq_empty && !evq_overflow, "R1 queue empty", {evq_empty, evq_overflow}, 2);
  endtask

  task automatic t_select;
    for (int r = 0; r < 64; r++) tbl_write(6'(r), 32'h0);
    tbl_write({5'd3, 1'b1}, 32'h0000_0010);
    tbl_write({5'd3, 1'b0}, 32'h0000_0080);
    send_msg(5'd3, 1'b1, 5'd4, 3, 16'h0C01, "captured");
  endtask

  task automatic t_reject;
    send_msg(5'd3, 1'b1, 5'd5, 2, 16'h0C02, "R4 other subaddress");
    send_msg(5'd3, 1'b0, 5'd4, 2, 16'h0C03, "R4 other direction");
    send_msg(5'd4, 1'b1, 5'd4, 1, 16'h0C04, "R4 other address");
  endtask

  task automatic t_rewrite;
    tbl_write({5'd3, 1'b0}, 32'h0000_0090);
    send_msg(5'd3, 1'b0, 5'd4, 1, 16'h0C05, "R11 new mask");
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 7; k++) send_msg(5'd3, 1'b1, 5'd4, 2, 16'h0D00 + 16'(k), "R6 wrap run");
    chk(mc == 4, "R6 pointer wrapped (model)", mc, 4);
    drain_queue("events");
  endtask

  task automatic t_overflow;
    send_msg(5'd3, 1'b1, 5'd4, 40, 16'h0E01, "long message");
    chk(mov == 1, "R10 overflow expected (model)", mov, 1);
    drain_queue("overflow");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_select;
    t_reject;
    t_rewrite;
    t_wrap;
    t_overflow;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule